// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the eight status flags of one serial channel and the small buffers behind them. The transmitter and receiver report events to it every cycle. The transmitter reports the busy level of its shift register and a pulse when it takes the pending byte. The receiver reports a pulse for each completed character, together with that character's stop-bit and parity error indications. From these events the block keeps a two-entry receive queue, a one-entry transmit holding register and four sticky error and completion flags.

Software reaches the block through a byte-wide register port that has separate read and write strobes. The status word can be read at one address, and its sticky flags are cleared by writing ones there. A write to the transmit-data address loads the holding register. A read of the receive-data address returns the oldest queued byte and removes it from the queue. Serial shifting, baud timing and interrupt routing belong to other blocks.

Top module: `uart_stat_ctl`

## Requirements
- R1: The status word is on `stat_o` and reads back at register address 0. Its bits are: bit 7 end-of-transmission, bit 6 framing error, bit 5 parity error, bit 4 overrun, bit 3 second-byte-ready, bit 2 transmit busy, bit 1 receive-data-ready, bit 0 transmit-buffer-empty.
- R2: End-of-transmission becomes 1 in the same cycle that the busy bit changes from 1 to 0.
- R3: A write to address 0 with a 1 in bit 7, 6, 5 or 4 clears that flag. A 0 in those bits leaves the flag unchanged.
- R4: A completed character with a stop-bit error sets the framing flag. A completed character with a parity error sets the parity flag.
- R5: Writes to address 0 do not change bits 3 to 0.
- R6: While reset is held and after reset is released, the status word is 0x01.
- R7: The busy bit follows `tx_busy_i` one clock later, whatever the state of the transmit holding register.
- R8: Receive-data-ready is 1 when at least one byte is queued. Second-byte-ready is 1 only when two bytes are queued.
- R9: A character that completes while two bytes are already queued, with no read in the same cycle, sets the overrun flag and is discarded.
- R10: A read strobe at address 2 returns the oldest queued byte in that cycle and removes it from the queue. Bytes come out in the order they arrived.
- R11: A write at address 1 loads the transmit holding register, which drives `tx_data_o`, and clears transmit-buffer-empty on the next clock. A pulse on `tx_take_i` sets transmit-buffer-empty again. If a load and a take fall in the same cycle, the load wins.
- R12: When a set event and a write-one clear reach the same sticky flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_busy_i | input | 1 | Transmit shift register busy level |
| tx_take_i | input | 1 | Pulse: shifter took the pending byte |
| rx_done_i | input | 1 | Pulse: a received character is complete |
| rx_byte_i | input | DW | Data of the completed character |
| rx_stop_err_i | input | 1 | Stop bit was 0 (qualified by rx_done_i) |
| rx_par_err_i | input | 1 | Parity mismatch (qualified by rx_done_i) |
| bus_addr_i | input | AW | Register address: 0 status, 1 transmit data, 2 receive data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for the addressed register |
| tx_data_o | output | DW | Contents of the transmit holding register |
| stat_o | output | 8 | Status word |

## Verification
The assertions assume that the receiver's error indications are used only when `rx_done_i` is high. They also assume that a write strobe is never issued together with a read strobe. The no-change property for the read-only bits assumes that no receive, take or busy change arrives in the cycle of the status write. The bench drives every strobe and event for a single clock on the falling edge. Each scenario task drives only the events it examines, and it raises read and write strobes in separate cycles.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int SW      = 8;
  localparam int B_EOT   = 7;
  localparam int B_FER   = 6;
  localparam int B_PER   = 5;
  localparam int B_OER   = 4;
  localparam int B_RD2   = 3;
  localparam int B_BUSY  = 2;
  localparam int B_RDY   = 1;
  localparam int B_TEMP  = 0;
  localparam int NSTICKY = 4;

  // sticky flag update: a set event takes priority over a write-one clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // occupancy of a queue after one cycle of push/pop
  function automatic logic [1:0] occ_next(logic [1:0] cur, logic push, logic pop);
    logic [1:0] r;
    r = cur;
    if (push && !pop) r = cur + 2'd1;
    if (pop && !push) r = cur - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/uart_sticky_flags.sv
module uart_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  import uart_stat_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= sticky_next(flag_o[g], set_i[g], clr_i[g]);
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [1:0]    occ_o,
  output logic          drop_o
);
  import uart_stat_pkg::*;

  localparam int DEPTH = 2;

  logic [DW-1:0] slot [DEPTH];
  logic          wp, rp;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i && (occ_o != 2'd0);
  assign push_ok = push_i && ((occ_o != 2'(DEPTH)) || pop_ok);
  assign drop_o  = push_i && !push_ok;
  assign head_o  = slot[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= 1'b0;
      rp    <= 1'b0;
      occ_o <= 2'd0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (push_ok) begin
        slot[wp] <= din_i;
        wp       <= ~wp;
      end
      if (pop_ok) rp <= ~rp;
      occ_o <= occ_next(occ_o, push_ok, pop_ok);
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (load_i) begin
        data_o <= din_i;
        full_o <= 1'b1;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_stat_ctl.sv
module uart_stat_ctl #(
  parameter int          DW       = 8,
  parameter int          AW       = 2,
  parameter logic [AW-1:0] A_STAT = 2'd0,
  parameter logic [AW-1:0] A_TXD  = 2'd1,
  parameter logic [AW-1:0] A_RXD  = 2'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_busy_i,
  input  logic          tx_take_i,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_stop_err_i,
  input  logic          rx_par_err_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic [7:0]    stat_o
);
  import uart_stat_pkg::*;

  // named internal events
  logic          st_wr, txd_wr, rxd_rd;
  logic          busy_q, busy_fall;
  logic          rx_drop;
  logic [1:0]    rx_occ;
  logic [DW-1:0] rx_head;
  logic          tx_full;
  logic [NSTICKY-1:0] st_set, st_clr, st_q;

  assign st_wr  = bus_wr_i && (bus_addr_i == A_STAT);
  assign txd_wr = bus_wr_i && (bus_addr_i == A_TXD);
  assign rxd_rd = bus_rd_i && (bus_addr_i == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= tx_busy_i;
  end
  assign busy_fall = busy_q && !tx_busy_i;

  uart_rx_queue #(.DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(rx_done_i), .din_i(rx_byte_i), .pop_i(rxd_rd),
    .head_o(rx_head), .occ_o(rx_occ), .drop_o(rx_drop)
  );

  uart_tx_hold #(.DW(DW)) u_txh (
    .clk(clk), .rst_n(rst_n),
    .load_i(txd_wr), .din_i(bus_wdata_i), .take_i(tx_take_i),
    .data_o(tx_data_o), .full_o(tx_full)
  );

  // sticky order: [3] eot, [2] framing, [1] parity, [0] overrun
  assign st_set = {busy_fall, rx_done_i && rx_stop_err_i,
                   rx_done_i && rx_par_err_i, rx_drop};
  assign st_clr = st_wr ? bus_wdata_i[B_EOT:B_OER] : '0;

  uart_sticky_flags #(.N(NSTICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_i(st_set), .clr_i(st_clr), .flag_o(st_q)
  );

  always_comb begin
    stat_o         = '0;
    stat_o[B_EOT]  = st_q[3];
    stat_o[B_FER]  = st_q[2];
    stat_o[B_PER]  = st_q[1];
    stat_o[B_OER]  = st_q[0];
    stat_o[B_RD2]  = (rx_occ == 2'd2);
    stat_o[B_BUSY] = busy_q;
    stat_o[B_RDY]  = (rx_occ != 2'd0);
    stat_o[B_TEMP] = !tx_full;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_STAT)     bus_rdata_o = DW'(stat_o);
    else if (bus_addr_i == A_TXD) bus_rdata_o = tx_data_o;
    else if (bus_addr_i == A_RXD) bus_rdata_o = rx_head;
  end
endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk #(
  parameter int          DW       = 8,
  parameter int          AW       = 2,
  parameter logic [AW-1:0] A_STAT = 2'd0,
  parameter logic [AW-1:0] A_TXD  = 2'd1,
  parameter logic [AW-1:0] A_RXD  = 2'd2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_busy_i,
  input logic          tx_take_i,
  input logic          rx_done_i,
  input logic          rx_stop_err_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_wr_i,
  input logic          bus_rd_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic [7:0]    stat_o,
  input logic          busy_fall
);
  p_reset_val_r6: assert property (@(posedge clk) !rst_n |-> stat_o == 8'h01);

  p_eot_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_o[2]) |-> stat_o[7]);

  p_rd2_needs_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[3] |-> stat_o[1]);

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && stat_o[3] && !(bus_rd_i && bus_addr_i == A_RXD)) |=> stat_o[4]);

  p_frame_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_stop_err_i) |=> stat_o[6]);

  p_w1c_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_STAT && bus_wdata_i[6] && !rx_done_i) |=> !stat_o[6]);

  p_ro_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_STAT && !bus_rd_i && !rx_done_i && !tx_take_i
     && (tx_busy_i == stat_o[2])) |=> $stable(stat_o[3:0]));

  p_load_clears_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == A_TXD) |=> !stat_o[0]);

  p_busy_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !stat_o[2]);
endmodule

bind uart_stat_ctl uart_stat_chk #(
  .DW(DW), .AW(AW), .A_STAT(A_STAT), .A_TXD(A_TXD), .A_RXD(A_RXD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy_i(tx_busy_i), .tx_take_i(tx_take_i),
  .rx_done_i(rx_done_i), .rx_stop_err_i(rx_stop_err_i),
  .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_wdata_i(bus_wdata_i), .stat_o(stat_o), .busy_fall(busy_fall)
);

// File: tb/uart_stat_ctl_bench.sv
module uart_stat_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_busy_i = 1'b0, tx_take_i = 1'b0, rx_done_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       rx_stop_err_i = 1'b0, rx_par_err_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o, tx_data_o, stat_o;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  uart_stat_ctl u_uart_stat_ctl (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_addr_i = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0; bus_addr_i = 2'd0;
  endtask

  task automatic rx(logic [7:0] b, logic se, logic pe);
    rx_byte_i = b; rx_stop_err_i = se; rx_par_err_i = pe; rx_done_i = 1'b1;
    @(negedge clk);
    rx_done_i = 1'b0; rx_stop_err_i = 1'b0; rx_par_err_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R6 reset word", stat_o, 8'h01);
    rd(2'd0, d);
    chk("R1 status at addr 0", d, 8'h01);
  endtask

  task automatic t_busy_eot();
    tx_busy_i = 1'b1;
    @(negedge clk);
    chk("R7 busy follows", stat_o, 8'h05);
    tx_busy_i = 1'b0;
    @(negedge clk);
    chk("R2 eot on busy fall", stat_o, 8'h81);
    wr(2'd0, 8'h00);
    chk("R3 write zero keeps eot", stat_o, 8'h81);
    wr(2'd0, 8'h80);
    chk("R3 write one clears eot", stat_o, 8'h01);
  endtask

  task automatic t_busy_indep();
    wr(2'd1, 8'h11);
    tx_busy_i = 1'b1;
    @(negedge clk);
    chk("R7 busy with full buffer", stat_o & 8'h05, 8'h04);
    tx_take_i = 1'b1;
    @(negedge clk);
    tx_take_i = 1'b0;
    chk("R7 busy after take", stat_o & 8'h05, 8'h05);
    tx_busy_i = 1'b0;
    @(negedge clk);
    wr(2'd0, 8'h80);
    chk("R2 cleanup", stat_o, 8'h01);
  endtask

  task automatic t_rx_order();
    logic [7:0] d;
    rx(8'hA5, 1'b0, 1'b0);
    chk("R8 one byte", stat_o, 8'h03);
    rx(8'h3C, 1'b0, 1'b0);
    chk("R8 two bytes", stat_o, 8'h0B);
    rd(2'd2, d);
    chk("R10 oldest first", d, 8'hA5);
    chk("R8 one left", stat_o, 8'h03);
    rd(2'd2, d);
    chk("R10 second byte", d, 8'h3C);
    chk("R8 empty", stat_o, 8'h01);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    rx(8'h11, 1'b0, 1'b0);
    rx(8'h22, 1'b0, 1'b0);
    rx(8'h33, 1'b0, 1'b0);
    chk("R9 overrun flag", stat_o, 8'h1B);
    rd(2'd2, d);
    chk("R9 first kept", d, 8'h11);
    rd(2'd2, d);
    chk("R9 second kept", d, 8'h22);
    chk("R9 third dropped", stat_o, 8'h11);
    wr(2'd0, 8'h10);
    chk("R3 clear overrun", stat_o, 8'h01);
  endtask

  task automatic t_errors();
    logic [7:0] d;
    rx(8'h01, 1'b1, 1'b0);
    chk("R4 framing", stat_o, 8'h43);
    rx(8'h02, 1'b0, 1'b1);
    chk("R4 parity", stat_o, 8'h6B);
    rd(2'd2, d);
    rd(2'd2, d);
    wr(2'd0, 8'h20);
    chk("R3 clear parity only", stat_o, 8'h41);
    wr(2'd0, 8'h40);
    chk("R3 clear framing", stat_o, 8'h01);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    rx(8'h77, 1'b0, 1'b0);
    wr(2'd0, 8'h0F);
    chk("R5 ro bits after 0x0F", stat_o, 8'h03);
    wr(2'd0, 8'hF0);
    chk("R5 ro bits after 0xF0", stat_o, 8'h03);
    rd(2'd2, d);
    chk("R10 byte intact", d, 8'h77);
  endtask

  task automatic t_txbuf();
    logic [7:0] d;
    wr(2'd1, 8'h5A);
    chk("R11 empty cleared", stat_o, 8'h00);
    chk("R11 holding data", tx_data_o, 8'h5A);
    bus_addr_i = 2'd1; bus_wdata_i = 8'hC3; bus_wr_i = 1'b1; tx_take_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; tx_take_i = 1'b0; bus_addr_i = 2'd0;
    chk("R11 load beats take", stat_o, 8'h00);
    rd(2'd1, d);
    chk("R11 new data", d, 8'hC3);
    tx_take_i = 1'b1;
    @(negedge clk);
    tx_take_i = 1'b0;
    chk("R11 take sets empty", stat_o, 8'h01);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    rx(8'h09, 1'b1, 1'b0);
    bus_addr_i = 2'd0; bus_wdata_i = 8'h40; bus_wr_i = 1'b1;
    rx_byte_i = 8'h0A; rx_stop_err_i = 1'b1; rx_done_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; rx_done_i = 1'b0; rx_stop_err_i = 1'b0;
    chk("R12 set beats clear", stat_o, 8'h4B);
    rd(2'd2, d);
    rd(2'd2, d);
    wr(2'd0, 8'h40);
    chk("R12 later clear works", stat_o, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_eot();
    t_busy_indep();
    t_rx_order();
    t_overrun();
    t_errors();
    t_readonly();
    t_txbuf();
    t_set_wins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule